// File: doc/BRIEF.md
# Processor Power Mode Controller

This block controls the low-power modes of a small 8-bit processor core. Software writes a two-bit select register. The requested mode starts only after the writing instruction has retired, which the core signals with an instruction-complete strobe. The controller then halts the CPU. In Idle it keeps the system clock and the peripherals running. In Stop it gates off the system clock and all timers and interrupt sources. An enabled pending interrupt ends Idle: the Idle select bit clears, the halt drops, and the core services the interrupt and then continues after the instruction that requested Idle. Stop ignores interrupts and ends only through a reset.

Reset requests come from an external source and from internal sources such as the watchdog. Because the controller keeps the peripherals clocked in Idle, the watchdog keeps counting and can end Idle. A clock monitor runs on an always-on reference clock. It watches an activity toggle derived from the gated system clock. When that toggle stops for the configured timeout (100 µs by default) while the monitor is enabled, it raises an internal reset, and that reset ends Stop. Every reset request is stretched to a fixed number of reference cycles and sent out to restart the core at address 0x0000. The same stretched request is synchronised back into the system domain, where it clears all mode state.

All pins are plain control and status signals with no valid/ready handshake. The write port accepts a value in any cycle and has no back-pressure.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The select register has two bits. Bit 0 requests Idle and bit 1 requests Stop. When `wr_en` is high at a rising `clk` edge, the register loads `wr_sel`. With both bits clear, an instruction-complete strobe leaves the core running (`cpu_halt`=0, `clk_en`=1, `periph_en`=1).
- R2: A mode starts at the first `instr_done` that is sampled in a cycle after the write cycle. A strobe in the same cycle as the write does not start it. The outputs change one `clk` cycle after that strobe.
- R3: If both select bits are written as 1, Stop is entered rather than Idle.
- R4: In Idle, `cpu_halt`=1, `clk_en`=1 and `periph_en`=1.
- R5: In Stop, `cpu_halt`=1, `clk_en`=0 and `periph_en`=0.
- R6: `irq_pend` sampled high in Idle releases `cpu_halt` on the next cycle and clears the Idle select bit. A later `instr_done` therefore does not halt again.
- R7: In Stop, `irq_pend` has no effect and the Stop outputs hold until a reset.
- R8: A one-cycle `ext_rst_req` or `int_rst_req` drives `rst_req` high from the next `ref_clk` edge for exactly `RST_HOLD` reference cycles. The stretched request returns the core to the running state and clears both select bits, ending Idle or Stop.
- R9: With `mcd_en` high, `rst_req` never rises while the system clock runs. Once Stop gates the clock, `rst_req` rises about `REF_CLK_KHZ*MCD_TIMEOUT_US/1000` reference cycles later, and the core returns to running.
- R10: With `mcd_en` low, a stopped clock raises no reset and Stop persists.
- R11: While `por_n` is low, the block returns to the running state with `rst_req`=0 and both select bits clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Ungated system clock root |
| ref_clk | input | 1 | Always-on reference clock for monitor and reset stretcher |
| por_n | input | 1 | Power-on clear, active low, sampled on both clocks |
| wr_en | input | 1 | Select register write strobe |
| wr_sel | input | 2 | Select value: bit 0 Idle, bit 1 Stop |
| instr_done | input | 1 | Instruction-complete strobe from the core |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_rst_req | input | 1 | External reset request, `ref_clk` domain |
| int_rst_req | input | 1 | Internal (e.g. watchdog) reset request, `ref_clk` domain |
| mcd_en | input | 1 | Enables the missing-clock reset |
| cpu_halt | output | 1 | Halts the CPU |
| clk_en | output | 1 | System clock gate enable |
| periph_en | output | 1 | Timer and peripheral clock enable |
| rst_req | output | 1 | Stretched reset request to the core |

## Verification
Two events can land on the same `clk` edge: a select write and an instruction-complete strobe. The bench sweeps every select value. In each case it either drives the write and the strobe together or separates them by zero to three idle cycles. It judges that no halt follows the coincident strobe and that the correct mode starts exactly one cycle after the next strobe. A second overlap is an interrupt held high during Stop while a reset request crosses in from the reference domain. The bench requires that the interrupt never releases the halt, that the stretched reset has exactly the expected width, and that it then clears both select bits.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int SEL_W        = 2;
  localparam int SEL_IDLE_BIT = 0;
  localparam int SEL_STOP_BIT = 1;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2
  } pm_state_e;

  typedef struct packed {
    logic cpu_halt;
    logic clk_en;
    logic periph_en;
  } pm_gates_t;

  // Output decode per mode.
  function automatic pm_gates_t gates_for(input pm_state_e st);
    pm_gates_t g;
    case (st)
      PM_IDLE: g = '{cpu_halt: 1'b1, clk_en: 1'b1, periph_en: 1'b1};
      PM_STOP: g = '{cpu_halt: 1'b1, clk_en: 1'b0, periph_en: 1'b0};
      default: g = '{cpu_halt: 1'b0, clk_en: 1'b1, periph_en: 1'b1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pmc_sync.sv
// Multi-flop level synchroniser with a synchronous clear.
module pmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic srst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!srst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pmc_activity.sv
// Divided activity toggle. It advances only while the system clock is
// enabled, so it freezes when Stop gates the clock.
module pmc_activity #(
  parameter int ACT_W = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic run_en,
  output logic act_tgl
);
  logic [ACT_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      div_q <= '0;
    end else if (run_en) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign act_tgl = div_q[ACT_W-1];
endmodule

// File: rtl/pmc_clk_monitor.sv
// Missing-clock detector on the reference clock. Each activity edge
// restarts the count. Reaching TIMEOUT cycles without one raises a
// single-cycle fire pulse.
module pmc_clk_monitor #(
  parameter int TIMEOUT     = 2500,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic por_n,
  input  logic hold_off,
  input  logic mcd_en,
  input  logic act_tgl,
  output logic fire
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(TIMEOUT);

  logic          act_s;
  logic          act_d;
  logic          act_edge;
  logic [CW-1:0] cnt_q;

  pmc_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
    .clk    (ref_clk),
    .srst_n (por_n),
    .d      (act_tgl),
    .q      (act_s)
  );

  always_ff @(posedge ref_clk) begin
    if (!por_n) begin
      act_d <= 1'b0;
    end else begin
      act_d <= act_s;
    end
  end

  assign act_edge = act_s ^ act_d;

  always_ff @(posedge ref_clk) begin
    if (!por_n || hold_off || !mcd_en || act_edge) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire = mcd_en && !hold_off && !act_edge && (cnt_q == CNT_LAST);
endmodule

// File: rtl/pmc_reset_gen.sv
// Reset stretcher: every request reloads a down-counter, and the output
// stays high while the counter is non-zero.
module pmc_reset_gen #(
  parameter int HOLD = 8
) (
  input  logic ref_clk,
  input  logic por_n,
  input  logic req,
  output logic rst_req
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_LD = HW'(HOLD);

  logic [HW-1:0] hold_q;

  always_ff @(posedge ref_clk) begin
    if (!por_n) begin
      hold_q <= '0;
    end else if (req) begin
      hold_q <= HOLD_LD;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assign rst_req = (hold_q != '0);
endmodule

// File: rtl/pmc_mode_fsm.sv
// Select register and mode state in the system domain.
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_sys,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             instr_done,
  input  logic             irq_pend,
  output logic             cpu_halt,
  output logic             clk_en,
  output logic             periph_en
);
  pm_state_e        state_q, state_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  pm_gates_t        gates;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    unique case (state_q)
      PM_RUN: begin
        if (wr_en) begin
          sel_d = wr_sel;
        end
        // Only a value already registered can start a mode: this is the
        // retire of the writing instruction.
        if (instr_done && (sel_q != '0)) begin
          state_d = sel_q[SEL_STOP_BIT] ? PM_STOP : PM_IDLE;
        end
      end
      PM_IDLE: begin
        if (irq_pend) begin
          sel_d[SEL_IDLE_BIT] = 1'b0;
          state_d             = PM_RUN;
        end
      end
      PM_STOP: begin
        state_d = PM_STOP;
      end
      default: begin
        state_d = PM_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n || rst_sys) begin
      state_q <= PM_RUN;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
    end
  end

  assign gates     = gates_for(state_q);
  assign cpu_halt  = gates.cpu_halt;
  assign clk_en    = gates.clk_en;
  assign periph_en = gates.periph_en;
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power mode controller top: mode FSM, activity toggle, clock monitor,
// reset stretcher and the reset return path.
module pwr_mode_ctrl #(
  parameter int REF_CLK_KHZ    = 25000,
  parameter int MCD_TIMEOUT_US = 100,
  parameter int RST_HOLD       = 8,
  parameter int ACT_W          = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       ref_clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic       instr_done,
  input  logic       irq_pend,
  input  logic       ext_rst_req,
  input  logic       int_rst_req,
  input  logic       mcd_en,
  output logic       cpu_halt,
  output logic       clk_en,
  output logic       periph_en,
  output logic       rst_req
);
  localparam int TIMEOUT_CYC = (REF_CLK_KHZ * MCD_TIMEOUT_US) / 1000;

  logic act_tgl;
  logic mcd_fire;
  logic any_req;
  logic rst_sys;

  pmc_mode_fsm u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .rst_sys    (rst_sys),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .instr_done (instr_done),
    .irq_pend   (irq_pend),
    .cpu_halt   (cpu_halt),
    .clk_en     (clk_en),
    .periph_en  (periph_en)
  );

  pmc_activity #(.ACT_W(ACT_W)) u_act (
    .clk     (clk),
    .por_n   (por_n),
    .run_en  (clk_en),
    .act_tgl (act_tgl)
  );

  pmc_clk_monitor #(
    .TIMEOUT     (TIMEOUT_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mon (
    .ref_clk  (ref_clk),
    .por_n    (por_n),
    .hold_off (rst_req),
    .mcd_en   (mcd_en),
    .act_tgl  (act_tgl),
    .fire     (mcd_fire)
  );

  assign any_req = ext_rst_req | int_rst_req | mcd_fire;

  pmc_reset_gen #(.HOLD(RST_HOLD)) u_rst (
    .ref_clk (ref_clk),
    .por_n   (por_n),
    .req     (any_req),
    .rst_req (rst_req)
  );

  pmc_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .srst_n (por_n),
    .d      (rst_req),
    .q      (rst_sys)
  );
endmodule

// File: rtl/pwr_mode_ctrl_sva.sv
module pwr_mode_ctrl_sva (
  input logic clk,
  input logic ref_clk,
  input logic por_n,
  input logic instr_done,
  input logic irq_pend,
  input logic ext_rst_req,
  input logic int_rst_req,
  input logic rst_sys,
  input logic cpu_halt,
  input logic clk_en,
  input logic periph_en,
  input logic rst_req
);
  // R2
  a_r2_halt_after_done: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_halt) |-> $past(instr_done));

  // R6
  a_r6_irq_ends_idle: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_halt && clk_en && irq_pend) |=> !cpu_halt);

  // R7
  a_r7_stop_holds: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_halt && !clk_en && !rst_sys) |=> (cpu_halt && !clk_en));

  // R8
  a_r8_reset_clears_mode: assert property (@(posedge clk) disable iff (!por_n)
    rst_sys |=> (!cpu_halt && clk_en && periph_en));

  // R8
  a_r8_request_stretched: assert property (@(posedge ref_clk) disable iff (!por_n)
    (ext_rst_req || int_rst_req) |=> rst_req);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_sva u_sva (
  .clk         (clk),
  .ref_clk     (ref_clk),
  .por_n       (por_n),
  .instr_done  (instr_done),
  .irq_pend    (irq_pend),
  .ext_rst_req (ext_rst_req),
  .int_rst_req (int_rst_req),
  .rst_sys     (rst_sys),
  .cpu_halt    (cpu_halt),
  .clk_en      (clk_en),
  .periph_en   (periph_en),
  .rst_req     (rst_req)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int KHZ  = 160;
  localparam int US   = 100;
  localparam int TC   = (KHZ * US) / 1000;  // 16 reference cycles
  localparam int HOLD = 4;
  // {cpu_halt, clk_en, periph_en}
  localparam int G_RUN  = 3;
  localparam int G_IDLE = 7;
  localparam int G_STOP = 4;

  logic       clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic       instr_done = 1'b0;
  logic       irq_pend = 1'b0;
  logic       ext_rst_req = 1'b0;
  logic       int_rst_req = 1'b0;
  logic       mcd_en = 1'b0;
  logic       cpu_halt, clk_en, periph_en, rst_req;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #20 ref_clk = ~ref_clk;
  end

  pwr_mode_ctrl #(
    .REF_CLK_KHZ    (KHZ),
    .MCD_TIMEOUT_US (US),
    .RST_HOLD       (HOLD)
  ) u_pwr_mode_ctrl (
    .clk         (clk),
    .ref_clk     (ref_clk),
    .por_n       (por_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .instr_done  (instr_done),
    .irq_pend    (irq_pend),
    .ext_rst_req (ext_rst_req),
    .int_rst_req (int_rst_req),
    .mcd_en      (mcd_en),
    .cpu_halt    (cpu_halt),
    .clk_en      (clk_en),
    .periph_en   (periph_en),
    .rst_req     (rst_req)
  );

  function automatic int gates_now();
    return int'({cpu_halt, clk_en, periph_en});
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_done();
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
  endtask

  task automatic write_sel(input int s);
    wr_en  = 1'b1;
    wr_sel = 2'(s);
    @(negedge clk);
    wr_en  = 1'b0;
  endtask

  // One-cycle request in the reference domain; measure width, then recovery.
  task automatic do_reset(input bit use_int, input string tag);
    int w;
    @(negedge ref_clk);
    if (use_int) int_rst_req = 1'b1;
    else         ext_rst_req = 1'b1;
    @(negedge ref_clk);
    int_rst_req = 1'b0;
    ext_rst_req = 1'b0;
    w = 0;
    while (rst_req === 1'b1 && w < 100) begin
      w++;
      @(negedge ref_clk);
    end
    chk({tag, " R8 reset width"}, w, HOLD);
    repeat (5) @(negedge clk);
    chk({tag, " R8 running after reset"}, gates_now(), G_RUN);
    pulse_done();
    chk({tag, " R8 selects cleared"}, gates_now(), G_RUN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1..R11 run): actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    repeat (4) @(negedge ref_clk);
    @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset state gates", gates_now(), G_RUN);
    chk("R11 reset state rst_req", int'(rst_req), 0);

    // Sweep: select value x coincident strobe x gap x exit path.
    for (int s = 0; s < 4; s++) begin
      for (int same = 0; same < 2; same++) begin
        for (int gap = 0; gap < 4; gap++) begin
          for (int alt = 0; alt < 2; alt++) begin
            int exp;
            string tag;
            exp = (s == 0) ? G_RUN : (s == 1) ? G_IDLE : G_STOP;
            tag = (s == 0) ? "R1" : (s == 1) ? "R4" : (s == 2) ? "R5" : "R3";
            wr_en = 1'b1;
            wr_sel = 2'(s);
            instr_done = 1'(same);
            @(negedge clk);
            wr_en = 1'b0;
            instr_done = 1'b0;
            chk("R2 no halt on write-cycle strobe", gates_now(), G_RUN);
            repeat (gap) @(negedge clk);
            chk("R2 no halt before strobe", gates_now(), G_RUN);
            pulse_done();
            chk({tag, " mode after strobe"}, gates_now(), exp);
            if (s == 1) begin
              if (alt == 0) begin
                irq_pend = 1'b1;
                @(negedge clk);
                irq_pend = 1'b0;
                chk("R6 interrupt releases halt", gates_now(), G_RUN);
                pulse_done();
                chk("R6 idle bit cleared", gates_now(), G_RUN);
              end else begin
                do_reset(1'b1, "idle watchdog");
              end
            end else if (s >= 2) begin
              irq_pend = 1'b1;
              repeat (3) @(negedge clk);
              chk("R7 stop ignores interrupt", gates_now(), G_STOP);
              irq_pend = 1'b0;
              do_reset(1'(alt), "stop");
            end
          end
        end
      end
    end

    // R9: no monitor reset while the clock runs.
    mcd_en = 1'b1;
    seen = 1'b0;
    repeat (100) begin
      @(negedge ref_clk);
      if (rst_req) seen = 1'b1;
    end
    chk("R9 quiet while clock runs", int'(seen), 0);

    // R9: stopped clock trips the monitor.
    @(negedge clk);
    write_sel(2);
    pulse_done();
    chk("R9 entered stop", gates_now(), G_STOP);
    n = 0;
    while (!rst_req && n < TC + 40) begin
      @(negedge ref_clk);
      n++;
    end
    vectors++;
    if (n < TC - 3 || n > TC + 8) begin
      fails++;
      $display("FAIL R9 timeout window: actual %0d expected %0d..%0d", n, TC - 3, TC + 8);
    end
    while (rst_req) @(negedge ref_clk);
    repeat (5) @(negedge clk);
    chk("R9 running after monitor reset", gates_now(), G_RUN);
    mcd_en = 1'b0;

    // R10: disabled monitor leaves Stop in place.
    write_sel(3);
    pulse_done();
    seen = 1'b0;
    repeat (4 * TC) begin
      @(negedge ref_clk);
      if (rst_req) seen = 1'b1;
    end
    chk("R10 no reset when monitor off", int'(seen), 0);
    @(negedge clk);
    chk("R10 stop persists", gates_now(), G_STOP);
    do_reset(1'b0, "R10 exit");

    // R11: power-on clear during Idle.
    write_sel(1);
    pulse_done();
    chk("R11 entered idle", gates_now(), G_IDLE);
    por_n = 1'b0;
    repeat (3) @(negedge ref_clk);
    @(negedge clk);
    chk("R11 running under por", gates_now(), G_RUN);
    chk("R11 rst_req low under por", int'(rst_req), 0);
    por_n = 1'b1;
    @(negedge clk);
    pulse_done();
    chk("R11 selects cleared", gates_now(), G_RUN);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule